// File: doc/BRIEF.md
# Quad Double-Buffered DAC Code Register Bank

This block keeps the digital codes of four converter channels in two ranks. A decoded command word (channel address, power bit, hold bit, data code and a one-cycle valid strobe) arrives from a serial front end that has already checked its framing. Every valid word stores its code in the staging register of the addressed channel. When the word's hold bit is 0, the word also requests a transfer to all four live registers at once. A live register takes a new value only if its staging register was written since that channel's last transfer. This avoids needless output updates. A per-channel one-cycle load pulse shows exactly which live registers were reloaded.

The same words control a shared power state machine with two states, `PWR_ACTIVE` and `PWR_SLEEP`. Every valid word sets the next state from its power bit. Power bit 0 takes the transition ACTIVE→SLEEP or SLEEP→SLEEP. Power bit 1 takes SLEEP→ACTIVE or ACTIVE→ACTIVE. Without a valid word the state holds. In `PWR_SLEEP` all four drive-enable outputs are 0, which marks the outputs as high impedance. Register contents are never touched by a power change. Staging writes and transfers continue while asleep. Each channel holds its own pending flag, which is set by a staging write and cleared by a load of its live register.

Top module: `dac_code_bank`

## Requirements
- R1: After reset every live code is 0, every drive enable is 1 (state `PWR_ACTIVE`) and no load pulse is active.
- R2: A word with `cmd_valid`=1 stores `cmd_code` in the staging register of the channel given by `cmd_chan` (0..3 selects channel 0..3).
- R3: A valid word with `cmd_hold`=1 leaves every live code unchanged on the following cycle.
- R4: A valid word with `cmd_hold`=0 loads, at the same clock edge, every channel with a pending staging write. This includes the addressed channel, which receives `cmd_code` of that word directly. The new codes are visible in the cycle after the word.
- R5: A channel whose staging register has not been written since its last load keeps its live code and produces no load pulse when a transfer is requested. Its pending flag is clear after any load.
- R6: A valid word with `cmd_power`=0 forces all four `dac_drive_en` bits to 0 from the next cycle. A valid word with `cmd_power`=1 sets them all to 1. The power bit acts regardless of the addressed channel.
- R7: Power transitions leave all codes unchanged, and staging writes and transfers made while asleep take effect normally.
- R8: `code_loaded[i]` is high for exactly the one cycle after channel i's live register is loaded, with bit i belonging to channel i.
- R9: Cycles with `cmd_valid`=0 change no register, no pending flag and no power state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Strobe marking one complete, validated command word |
| cmd_chan | input | 2 | Addressed channel |
| cmd_power | input | 1 | 1 = normal operation, 0 = power down all channels |
| cmd_hold | input | 1 | 1 = stage only, 0 = also transfer all pending channels |
| cmd_code | input | 12 | Channel code |
| dac_code | output | 48 | Live codes, channel i at bits [12*i+11:12*i] |
| dac_drive_en | output | 4 | Per-channel drive enable, 0 = high impedance |
| code_loaded | output | 4 | One-cycle pulse per channel after its live register loads |

## Verification
The hardest situation to reach is a transfer that finds some channels pending and others clean. Pending flags cannot be observed directly, so the stimulus has to build them up on purpose. Several hold-bit-1 writes are made first, then a transfer, and then a second transfer that addresses a different channel. The second transfer must reload only that channel. The same approach is then used across a power-down period: a staging write is made while asleep, and a later transfer reloads both the staged channel and the addressed one, while the drive enables remain low.

// File: rtl/dac_bank_pkg.sv
package dac_bank_pkg;
    typedef enum logic [0:0] {
        PWR_ACTIVE = 1'b0,
        PWR_SLEEP  = 1'b1
    } pwr_state_t;
endpackage

// File: rtl/dac_power_fsm.sv
module dac_power_fsm
    import dac_bank_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cmd_valid,
    input  logic           cmd_power,
    output logic [NCH-1:0] drive_en
);
    pwr_state_t state_q, state_d;

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PWR_ACTIVE: if (cmd_valid && !cmd_power) state_d = PWR_SLEEP;
            PWR_SLEEP:  if (cmd_valid &&  cmd_power) state_d = PWR_ACTIVE;
            default:    state_d = PWR_ACTIVE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PWR_ACTIVE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        unique case (state_q)
            PWR_ACTIVE: drive_en = '1;
            PWR_SLEEP:  drive_en = '0;
            default:    drive_en = '0;
        endcase
    end

    p_power_follows_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> (drive_en == {NCH{$past(cmd_power)}}));
    p_idle_keeps_power_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> $stable(drive_en));
endmodule

// File: rtl/dac_chan_slice.sv
module dac_chan_slice #(
    parameter int CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              xfer,
    input  logic [CODE_W-1:0] din,
    output logic [CODE_W-1:0] live_code,
    output logic              loaded
);
    logic [CODE_W-1:0] stage_q;
    logic              pending_q;
    logic              load;

    assign load = xfer && (wr || pending_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q   <= '0;
            live_code <= '0;
            pending_q <= 1'b0;
            loaded    <= 1'b0;
        end else begin
            loaded <= load;
            if (wr) stage_q <= din;
            if (load) begin
                live_code <= wr ? din : stage_q;
                pending_q <= 1'b0;
            end else if (wr) begin
                pending_q <= 1'b1;
            end
        end
    end

    p_stage_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (stage_q == $past(din)));
    p_hold_keeps_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer |=> $stable(live_code));
    p_clean_not_loaded_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && !wr && !pending_q) |=> (!loaded && $stable(live_code)));
    p_pending_cleared_r5: assert property (@(posedge clk) disable iff (!rst_n)
        xfer |=> !pending_q);
    p_loaded_matches_stage_r8: assert property (@(posedge clk) disable iff (!rst_n)
        loaded |-> (live_code == stage_q));
endmodule

// File: rtl/dac_code_bank.sv
module dac_code_bank
    import dac_bank_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int CODE_W = 12,
    localparam int ADDR_W = $clog2(NCH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_valid,
    input  logic [ADDR_W-1:0]     cmd_chan,
    input  logic                  cmd_power,
    input  logic                  cmd_hold,
    input  logic [CODE_W-1:0]     cmd_code,
    output logic [NCH*CODE_W-1:0] dac_code,
    output logic [NCH-1:0]        dac_drive_en,
    output logic [NCH-1:0]        code_loaded
);
    logic xfer_all;
    assign xfer_all = cmd_valid && !cmd_hold;

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        logic wr_sel;
        assign wr_sel = cmd_valid && (cmd_chan == ADDR_W'(i));
        dac_chan_slice #(.CODE_W(CODE_W)) u_slice (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr        (wr_sel),
            .xfer      (xfer_all),
            .din       (cmd_code),
            .live_code (dac_code[i*CODE_W +: CODE_W]),
            .loaded    (code_loaded[i])
        );
    end

    dac_power_fsm #(.NCH(NCH)) u_power (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_power (cmd_power),
        .drive_en  (dac_drive_en)
    );

    p_enables_uniform_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_drive_en == '0) || (dac_drive_en == '1));
    p_idle_no_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> ((code_loaded == '0) && $stable(dac_code)));
    p_addressed_loads_r4: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_all |=> (code_loaded[$past(cmd_chan)] &&
                      dac_code[$past(cmd_chan)*CODE_W +: CODE_W] == $past(cmd_code)));
endmodule

// File: tb/tb_dac_code_bank.sv
module tb_dac_code_bank;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;
    localparam int CW  = 12;

    typedef struct packed {
        logic          v;
        logic [1:0]    a;
        logic          p;
        logic          h;
        logic [CW-1:0] d;
        logic [CW-1:0] c3, c2, c1, c0;
        logic          en;
        logic [3:0]    up;
        logic [3:0]    req;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VECS [NVEC] = '{
        // v a    p    h    data     c3      c2      c1      c0     en   upd      req
        '{1'b1, 2'd0, 1'b1, 1'b1, 12'h111, 12'h000, 12'h000, 12'h000, 12'h000, 1'b1, 4'b0000, 4'd3}, // R3
        '{1'b1, 2'd1, 1'b1, 1'b1, 12'h222, 12'h000, 12'h000, 12'h000, 12'h000, 1'b1, 4'b0000, 4'd3}, // R3
        '{1'b0, 2'd2, 1'b1, 1'b0, 12'hFFF, 12'h000, 12'h000, 12'h000, 12'h000, 1'b1, 4'b0000, 4'd9}, // R9
        '{1'b1, 2'd2, 1'b1, 1'b0, 12'h333, 12'h000, 12'h333, 12'h222, 12'h111, 1'b1, 4'b0111, 4'd4}, // R4 R2
        '{1'b1, 2'd3, 1'b1, 1'b0, 12'h444, 12'h444, 12'h333, 12'h222, 12'h111, 1'b1, 4'b1000, 4'd5}, // R5
        '{1'b1, 2'd0, 1'b0, 1'b1, 12'h555, 12'h444, 12'h333, 12'h222, 12'h111, 1'b0, 4'b0000, 4'd6}, // R6 R7
        '{1'b1, 2'd1, 1'b0, 1'b0, 12'h666, 12'h444, 12'h333, 12'h666, 12'h555, 1'b0, 4'b0011, 4'd7}, // R7
        '{1'b1, 2'd2, 1'b1, 1'b1, 12'hABC, 12'h444, 12'h333, 12'h666, 12'h555, 1'b1, 4'b0000, 4'd6}, // R6
        '{1'b1, 2'd3, 1'b1, 1'b0, 12'hFFF, 12'hFFF, 12'hABC, 12'h666, 12'h555, 1'b1, 4'b1100, 4'd4}, // R4
        '{1'b0, 2'd0, 1'b0, 1'b0, 12'h000, 12'hFFF, 12'hABC, 12'h666, 12'h555, 1'b1, 4'b0000, 4'd8}, // R8
        '{1'b1, 2'd1, 1'b1, 1'b0, 12'h666, 12'hFFF, 12'hABC, 12'h666, 12'h555, 1'b1, 4'b0010, 4'd5}, // R5
        '{1'b1, 2'd0, 1'b1, 1'b0, 12'h000, 12'hFFF, 12'hABC, 12'h666, 12'h000, 1'b1, 4'b0001, 4'd8}  // R8
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic [1:0]        cmd_chan = '0;
    logic              cmd_power = 1'b1;
    logic              cmd_hold = 1'b1;
    logic [CW-1:0]     cmd_code = '0;
    logic [NCH*CW-1:0] dac_code;
    logic [NCH-1:0]    dac_drive_en;
    logic [NCH-1:0]    code_loaded;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dac_code_bank dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_valid    (cmd_valid),
        .cmd_chan     (cmd_chan),
        .cmd_power    (cmd_power),
        .cmd_hold     (cmd_hold),
        .cmd_code     (cmd_code),
        .dac_code     (dac_code),
        .dac_drive_en (dac_drive_en),
        .code_loaded  (code_loaded)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic check_outputs(input string req, input logic [NCH*CW-1:0] ec,
                                 input logic en, input logic [3:0] up);
        check(req, "codes", 64'(dac_code), 64'(ec));
        check(req, "drive_en", 64'(dac_drive_en), 64'({NCH{en}}));
        check(req, "loaded", 64'(code_loaded), 64'(up));
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check_outputs("R1", '0, 1'b1, 4'b0000);

        for (int i = 0; i < NVEC; i++) begin
            cmd_valid = VECS[i].v;
            cmd_chan  = VECS[i].a;
            cmd_power = VECS[i].p;
            cmd_hold  = VECS[i].h;
            cmd_code  = VECS[i].d;
            @(negedge clk);
            check_outputs($sformatf("R%0d", VECS[i].req),
                          {VECS[i].c3, VECS[i].c2, VECS[i].c1, VECS[i].c0},
                          VECS[i].en, VECS[i].up);
        end

        // R8: pulse drops after one cycle
        cmd_valid = 1'b0;
        @(negedge clk);
        check("R8", "pulse width", 64'(code_loaded), 64'(0));

        // R5: repeated transfer with nothing pending reloads only addressed channel
        cmd_valid = 1'b1; cmd_chan = 2'd2; cmd_power = 1'b1; cmd_hold = 1'b0; cmd_code = 12'h0F0;
        @(negedge clk);
        check("R5", "only addressed", 64'(code_loaded), 64'(4'b0100));
        check("R4", "addressed code", 64'(dac_code[2*CW +: CW]), 64'(12'h0F0));

        // R1: reset mid-run clears codes and wakes power state
        cmd_power = 1'b0; cmd_hold = 1'b1;
        @(negedge clk);
        check("R6", "asleep", 64'(dac_drive_en), 64'(0));
        cmd_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check_outputs("R1", '0, 1'b1, 4'b0000);

        // R2: staged write after reset lands via later transfer of another channel
        cmd_valid = 1'b1; cmd_chan = 2'd3; cmd_power = 1'b1; cmd_hold = 1'b1; cmd_code = 12'h7A5;
        @(negedge clk);
        cmd_chan = 2'd0; cmd_hold = 1'b0; cmd_code = 12'h001;
        @(negedge clk);
        cmd_valid = 1'b0;
        check_outputs("R2", {12'h7A5, 12'h000, 12'h000, 12'h001}, 1'b1, 4'b1001);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule